// File: doc/BRIEF.md
# Slice Storage Element Bank

This block models the bank of eight single-bit storage elements that sits behind the four logic functions of a programmable logic slice. The elements are grouped as four pairs. Each element has its own data input and its own clock enable. All elements share one clock, one active-high set/reset input and one global reset.

A bank-wide parameter decides whether the shared set/reset acts at a clock edge or at once. Per-element parameters decide two things: the value loaded by the global reset, and whether the shared set/reset drives the element high or low. The second element of every pair can be turned into a level-sensitive latch by a per-pair parameter. The first element of every pair always stays an edge-triggered flip-flop.

The global reset is asynchronous and overrides everything else. The shared set/reset overrides the clock enable. Element i is bit i of every vector port. Pair p owns bits 2p (first element) and 2p+1 (second element).

Top module: `slice_reg_bank`

## Requirements
- R1: While `gbl_rst` is high, every element i holds `INIT_VAL[i]`, and this takes effect at once without a clock edge.
- R2: While `sr_in` is active, element i is driven to `SR_SET[i]` (1 means set to 1, 0 means clear to 0), whatever its clock enable is.
- R3: When `SR_MODE` is synchronous, `sr_in` changes no element until a rising clock edge (latch elements: until the clock is high).
- R4: When `SR_MODE` is asynchronous, `sr_in` changes every element at once, with no clock edge.
- R5: A flip-flop element with `ce[i]`=1 and `sr_in`=0 loads `d[i]` at the rising clock edge.
- R6: An element with `ce[i]`=0 and no reset active keeps its value across clock edges.
- R7: A second element whose pair has its `LATCH_SEL` bit set is transparent: it follows `d` while `clk` is high and `ce` is 1. It holds its value while `clk` is low.
- R8: First elements, and second elements whose `LATCH_SEL` bit is clear, change only at a rising edge and ignore `d` changes while `clk` is high.
- R9: `gbl_rst` takes priority over `sr_in`. When both are high, every element shows `INIT_VAL`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock; also the gate of latch-mode elements |
| gbl_rst | input | 1 | Asynchronous global reset to the init values |
| sr_in | input | 1 | Shared active-high set/reset |
| ce | input | 2*NUM_PAIRS | Per-element clock enable |
| d | input | 2*NUM_PAIRS | Per-element data input |
| q | output | 2*NUM_PAIRS | Per-element stored value |

## Verification
Two pairs of functions can meet in one cycle. The first is a shared set/reset and an active clock enable carrying the opposite data. The second is the global reset and the shared set/reset asserted together. The bench raises `sr_in` with every enable high and `d` the complement of the set/reset pattern, then checks that the set/reset pattern wins. It raises `gbl_rst` and `sr_in` in the same half cycle and checks that the init pattern wins, in both the synchronous-mode and the asynchronous-mode instance. In the asynchronous instance it also samples half a cycle before the next edge, which separates immediate action from edge-timed action.

// File: rtl/slice_reg_pkg.sv
package slice_reg_pkg;
  typedef enum logic {
    SR_SYNC  = 1'b0,
    SR_ASYNC = 1'b1
  } sr_mode_e;

  typedef enum logic {
    STORE_FF    = 1'b0,
    STORE_LATCH = 1'b1
  } store_kind_e;

  function automatic store_kind_e second_kind(input logic latch_sel);
    return latch_sel ? STORE_LATCH : STORE_FF;
  endfunction
endpackage

// File: rtl/slice_ff_cell.sv
module slice_ff_cell
  import slice_reg_pkg::*;
#(
  parameter sr_mode_e SR_MODE  = SR_SYNC,
  parameter logic     INIT_BIT = 1'b0,
  parameter logic     SR_BIT   = 1'b0
) (
  input  logic clk,
  input  logic gbl_rst,
  input  logic sr_in,
  input  logic ce,
  input  logic d,
  output logic q
);
  generate
    if (SR_MODE == SR_ASYNC) begin : g_async
      always_ff @(posedge clk or posedge gbl_rst or posedge sr_in) begin
        if (gbl_rst)    q <= INIT_BIT;
        else if (sr_in) q <= SR_BIT;
        else if (ce)    q <= d;
      end
    end else begin : g_sync
      always_ff @(posedge clk or posedge gbl_rst) begin
        if (gbl_rst)    q <= INIT_BIT;
        else if (sr_in) q <= SR_BIT;
        else if (ce)    q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/slice_latch_cell.sv
module slice_latch_cell
  import slice_reg_pkg::*;
#(
  parameter sr_mode_e SR_MODE  = SR_SYNC,
  parameter logic     INIT_BIT = 1'b0,
  parameter logic     SR_BIT   = 1'b0
) (
  input  logic clk,
  input  logic gbl_rst,
  input  logic sr_in,
  input  logic ce,
  input  logic d,
  output logic q
);
  generate
    if (SR_MODE == SR_ASYNC) begin : g_async
      always_latch begin
        if (gbl_rst)        q = INIT_BIT;
        else if (sr_in)     q = SR_BIT;
        else if (clk && ce) q = d;
      end
    end else begin : g_sync
      always_latch begin
        if (gbl_rst)                q = INIT_BIT;
        else if (clk && sr_in)      q = SR_BIT;
        else if (clk && ce)         q = d;
      end
    end
  endgenerate
endmodule

// File: rtl/slice_reg_pair.sv
module slice_reg_pair
  import slice_reg_pkg::*;
#(
  parameter sr_mode_e    SR_MODE     = SR_SYNC,
  parameter logic [1:0]  INIT_PAIR   = 2'b00,
  parameter logic [1:0]  SR_PAIR     = 2'b00,
  parameter store_kind_e SECOND_KIND = STORE_FF
) (
  input  logic       clk,
  input  logic       gbl_rst,
  input  logic       sr_in,
  input  logic [1:0] ce,
  input  logic [1:0] d,
  output logic [1:0] q
);
  slice_ff_cell #(
    .SR_MODE (SR_MODE),
    .INIT_BIT(INIT_PAIR[0]),
    .SR_BIT  (SR_PAIR[0])
  ) u_first (
    .clk    (clk),
    .gbl_rst(gbl_rst),
    .sr_in  (sr_in),
    .ce     (ce[0]),
    .d      (d[0]),
    .q      (q[0])
  );

  generate
    if (SECOND_KIND == STORE_LATCH) begin : g_latch
      slice_latch_cell #(
        .SR_MODE (SR_MODE),
        .INIT_BIT(INIT_PAIR[1]),
        .SR_BIT  (SR_PAIR[1])
      ) u_second (
        .clk    (clk),
        .gbl_rst(gbl_rst),
        .sr_in  (sr_in),
        .ce     (ce[1]),
        .d      (d[1]),
        .q      (q[1])
      );
    end else begin : g_ff
      slice_ff_cell #(
        .SR_MODE (SR_MODE),
        .INIT_BIT(INIT_PAIR[1]),
        .SR_BIT  (SR_PAIR[1])
      ) u_second (
        .clk    (clk),
        .gbl_rst(gbl_rst),
        .sr_in  (sr_in),
        .ce     (ce[1]),
        .d      (d[1]),
        .q      (q[1])
      );
    end
  endgenerate
endmodule

// File: rtl/slice_reg_bank.sv
module slice_reg_bank
  import slice_reg_pkg::*;
#(
  parameter int                       NUM_PAIRS = 4,
  parameter sr_mode_e                 SR_MODE   = SR_SYNC,
  parameter logic [2*NUM_PAIRS-1:0]   INIT_VAL  = 8'hA6,
  parameter logic [2*NUM_PAIRS-1:0]   SR_SET    = 8'h39,
  parameter logic [NUM_PAIRS-1:0]     LATCH_SEL = 4'b0101
) (
  input  logic                   clk,
  input  logic                   gbl_rst,
  input  logic                   sr_in,
  input  logic [2*NUM_PAIRS-1:0] ce,
  input  logic [2*NUM_PAIRS-1:0] d,
  output logic [2*NUM_PAIRS-1:0] q
);
  localparam int NUM_ELEM = 2 * NUM_PAIRS;

  logic [NUM_ELEM-1:0] q_int;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    slice_reg_pair #(
      .SR_MODE    (SR_MODE),
      .INIT_PAIR  (INIT_VAL[2*p +: 2]),
      .SR_PAIR    (SR_SET[2*p +: 2]),
      .SECOND_KIND(second_kind(LATCH_SEL[p]))
    ) u_pair (
      .clk    (clk),
      .gbl_rst(gbl_rst),
      .sr_in  (sr_in),
      .ce     (ce[2*p +: 2]),
      .d      (d[2*p +: 2]),
      .q      (q_int[2*p +: 2])
    );
  end

  assign q = q_int;
endmodule

// File: rtl/slice_reg_bank_chk.sv
module slice_reg_bank_chk
  import slice_reg_pkg::*;
#(
  parameter int                     NUM_PAIRS = 4,
  parameter sr_mode_e               SR_MODE   = SR_SYNC,
  parameter logic [2*NUM_PAIRS-1:0] INIT_VAL  = 8'hA6,
  parameter logic [2*NUM_PAIRS-1:0] SR_SET    = 8'h39,
  parameter logic [NUM_PAIRS-1:0]   LATCH_SEL = 4'b0101
) (
  input logic                   clk,
  input logic                   gbl_rst,
  input logic                   sr_in,
  input logic [2*NUM_PAIRS-1:0] ce,
  input logic [2*NUM_PAIRS-1:0] d,
  input logic [2*NUM_PAIRS-1:0] q
);
  localparam int NUM_ELEM = 2 * NUM_PAIRS;

  // R1 / R9: global reset wins over everything
  always @(negedge clk) begin
    if (gbl_rst) begin
      assert_init_on_grst_R1: assert (q == INIT_VAL)
        else $error("init value not held under global reset");
    end
  end

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_elem
    // R6: no enable, no reset -> value kept
    assert_hold_no_ce_R6: assert property (@(posedge clk) disable iff (gbl_rst)
      (!ce[i] && !sr_in) |=> (sr_in || $stable(q[i])));

    if (SR_MODE == SR_SYNC) begin : g_sync
      // R2 / R3: set/reset seen at an edge lands on the element
      assert_sync_sr_R3: assert property (@(posedge clk) disable iff (gbl_rst)
        sr_in |=> (q[i] == SR_SET[i]));
    end else begin : g_async
      // R4: set/reset already in force when an edge arrives
      assert_async_sr_R4: assert property (@(posedge clk) disable iff (gbl_rst)
        sr_in |-> (q[i] == SR_SET[i]));
    end

    if ((i % 2 == 0) || !LATCH_SEL[i/2]) begin : g_ff_chk
      // R5: enabled flip-flop captures data
      assert_ff_load_R5: assert property (@(posedge clk) disable iff (gbl_rst)
        (ce[i] && !sr_in) |=> (sr_in || q[i] == $past(d[i])));
    end else begin : g_latch_chk
      // R7: open latch shows its data when the gate closes
      always @(negedge clk) begin
        if (!gbl_rst && !sr_in && ce[i]) begin
          assert_latch_follow_R7: assert (q[i] == d[i])
            else $error("latch element not transparent");
        end
      end
    end
  end
endmodule

bind slice_reg_bank slice_reg_bank_chk #(
  .NUM_PAIRS(NUM_PAIRS),
  .SR_MODE  (SR_MODE),
  .INIT_VAL (INIT_VAL),
  .SR_SET   (SR_SET),
  .LATCH_SEL(LATCH_SEL)
) u_chk (
  .clk    (clk),
  .gbl_rst(gbl_rst),
  .sr_in  (sr_in),
  .ce     (ce),
  .d      (d),
  .q      (q)
);

// File: tb/slice_reg_bank_test.sv
`timescale 1ns/100ps
module slice_reg_bank_test;
  import slice_reg_pkg::*;

  localparam int         NP    = 4;
  localparam int         NE    = 2 * NP;
  localparam logic [7:0] INITV = 8'hA6;
  localparam logic [7:0] SRV   = 8'h39;
  localparam logic [3:0] LSEL  = 4'b0101;
  localparam logic [7:0] LMASK = 8'h22; // latch elements 1 and 5

  logic          clk = 1'b0;
  logic          gbl_rst = 1'b0;
  logic          sr_in = 1'b0;
  logic [NE-1:0] ce = '0;
  logic [NE-1:0] d = '0;
  logic [NE-1:0] q_s;
  logic [NE-1:0] q_a;
  int            checks = 0;
  int            failures = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  slice_reg_bank #(
    .NUM_PAIRS(NP), .SR_MODE(SR_SYNC), .INIT_VAL(INITV),
    .SR_SET(SRV), .LATCH_SEL(LSEL)
  ) uut (
    .clk(clk), .gbl_rst(gbl_rst), .sr_in(sr_in), .ce(ce), .d(d), .q(q_s)
  );

  slice_reg_bank #(
    .NUM_PAIRS(NP), .SR_MODE(SR_ASYNC), .INIT_VAL(INITV),
    .SR_SET(SRV), .LATCH_SEL(LSEL)
  ) uut_a (
    .clk(clk), .gbl_rst(gbl_rst), .sr_in(sr_in), .ce(ce), .d(d), .q(q_a)
  );

  task automatic check(input string req, input logic [NE-1:0] act,
                       input logic [NE-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic to_low();
    @(negedge clk); #0.5;
  endtask

  task automatic to_high();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    #1 gbl_rst = 1'b1;
    #0.5;
    check("R1 sync inst async init", q_s, INITV);
    check("R1 async inst async init", q_a, INITV);
    to_low();
    gbl_rst = 1'b0;
  endtask

  task automatic t_load();
    to_low(); ce = 8'hFF; d = 8'h5A;
    to_high();
    check("R5 load 5A sync", q_s, 8'h5A);
    check("R5 load 5A async", q_a, 8'h5A);
    to_low(); d = 8'hA5;
    to_high();
    check("R5 load A5", q_s, 8'hA5);
  endtask

  task automatic t_enable();
    to_low(); ce = 8'h00; d = 8'h5A;
    to_high();
    check("R6 hold all", q_s, 8'hA5);
    check("R6 hold all async", q_a, 8'hA5);
    to_low(); ce = 8'h0F; d = 8'hFF;
    to_high();
    check("R6 partial enable", q_s, 8'hAF);
  endtask

  task automatic t_latch();
    to_low(); ce = 8'hFF; d = 8'h3C;
    to_high();
    check("R5 pre-latch load", q_s, 8'h3C);
    d = 8'hC3;
    #0.5;
    check("R7 R8 transparent high phase", q_s, 8'h1E);
    check("R7 R8 transparent async inst", q_a, 8'h1E);
    to_low(); d = 8'h0F;
    #0.5;
    check("R7 latch hold low phase", q_s, 8'h1E);
    to_high();
    check("R7 latch reopen", q_s, 8'h0F);
  endtask

  task automatic t_setreset();
    to_low(); ce = 8'h00; sr_in = 1'b1;
    #0.5;
    check("R4 async sr immediate", q_a, SRV);
    check("R3 sync sr waits", q_s, 8'h0F);
    to_high();
    check("R3 sync sr at edge ce low", q_s, SRV);
    to_low(); sr_in = 1'b0;
    to_high();
    check("R6 hold after sr", q_s, SRV);
    to_low(); ce = 8'hFF; d = ~SRV; sr_in = 1'b1;
    to_high();
    check("R2 sr beats ce sync", q_s, SRV);
    check("R2 sr beats ce async", q_a, SRV);
    to_low(); sr_in = 1'b0;
    to_high();
    check("R5 load after sr", q_s, ~SRV);
  endtask

  task automatic t_priority();
    to_low(); sr_in = 1'b1; gbl_rst = 1'b1;
    #0.5;
    check("R9 grst over sr async", q_a, INITV);
    check("R9 grst over sr sync", q_s, INITV);
    to_high();
    check("R9 grst over sr at edge", q_s, INITV);
    to_low(); gbl_rst = 1'b0; sr_in = 1'b0; ce = 8'h00;
    to_high();
    check("R6 hold init", q_s, INITV);
    ce = 8'hFF; d = 8'hFF; gbl_rst = 1'b1;
    #0.5;
    check("R1 grst high phase", q_s, INITV);
    to_low(); gbl_rst = 1'b0; ce = 8'h00;
  endtask

  initial begin
    t_reset();
    t_load();
    t_enable();
    t_latch();
    t_setreset();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule